// File: doc/BRIEF.md
# Nibble Compare Instruction Executor

This block carries out the two 4-bit compare instructions of a small nibble-wide microcontroller core. It receives a 12-bit instruction word with a start strobe and decodes one of two formats. In the immediate form a nibble operand is compared against a constant held in the instruction. In the register form it is compared against a second nibble operand. An operand can be register A, register B, or a data-memory nibble addressed by the X or the Y pointer.

The block subtracts the second operand from the first and discards the difference. Only the carry and zero flags are kept, and no operand location is written. Memory operands are fetched through a synchronous read port. When both operands are in memory, the two reads are made one after the other. The instruction takes a fixed number of cycles, signalled by busy, with a one-cycle done pulse at the end. A start carrying any other opcode leaves the flags unchanged and produces a one-cycle illegal indication.

Top module: `nib_cmp_exec`

## Requirements
- R1: An instruction whose upper six bits are 110111 (0xDC0 to 0xDFF) is the immediate form. Bits 5:4 select the first operand and bits 3:0 are the constant it is compared against.
- R2: An instruction whose upper eight bits are 0xF0 (0xF00 to 0xF0F) is the register form. Bits 3:2 select the first operand and bits 1:0 select the second operand.
- R3: A 2-bit operand select means: 00 register A, 01 register B, 10 memory at ptr_x, 11 memory at ptr_y.
- R4: After a compare, flag_c is 1 exactly when the first operand is unsigned-less than the second operand.
- R5: After a compare, flag_z is 1 exactly when the two operands are equal.
- R6: A memory operand is read by raising mem_rd with mem_addr for one cycle; the data is taken from mem_rdata in the following cycle. The first operand's read is presented in busy cycle 1 and the second operand's read in busy cycle 2.
- R7: An accepted start raises busy for exactly CYCLES cycles. done is high for one cycle, in the last busy cycle, and the flags take their new values in that same cycle.
- R8: A start with an opcode outside both ranges raises illegal for one cycle, does not raise busy, and leaves both flags unchanged.
- R9: A start that arrives while busy is high is ignored: it produces no extra done, no illegal pulse, and no change to the result.
- R10: After reset, flag_c, flag_z, busy, done, illegal and mem_rd are 0. The flags keep their value between instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin executing instr (taken when not busy) |
| instr | input | 12 | Instruction word |
| reg_a | input | 4 | Contents of register A |
| reg_b | input | 4 | Contents of register B |
| ptr_x | input | ADDR_W | X data pointer |
| ptr_y | input | ADDR_W | Y data pointer |
| mem_rd | output | 1 | Data-memory read request |
| mem_addr | output | ADDR_W | Data-memory read address |
| mem_rdata | input | 4 | Read data, valid the cycle after the request |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle end-of-instruction pulse |
| illegal | output | 1 | One-cycle pulse for an unrecognised opcode |
| flag_c | output | 1 | Carry flag (first operand less than second) |
| flag_z | output | 1 | Zero flag (operands equal) |

## Verification
The bench builds the block with ADDR_W set to 8 and CYCLES left at 7. The narrow address lets the bench preload every memory nibble. It also makes it easy for both pointers to hit the same or different cells, including the case where both operands are in memory. With CYCLES at its default, the bench measures the real busy window and the position of the done pulse, and can inject a start in the middle of an instruction.

// File: rtl/nib_cmp_pkg.sv
package nib_cmp_pkg;
  localparam int NIB_W   = 4;
  localparam int INSTR_W = 12;

  typedef enum logic [1:0] {
    LOC_A  = 2'b00,
    LOC_B  = 2'b01,
    LOC_MX = 2'b10,
    LOC_MY = 2'b11
  } loc_e;

  typedef struct packed {
    logic             legal;
    logic             imm_form;
    loc_e             dst_sel;
    loc_e             src_sel;
    logic [NIB_W-1:0] imm;
  } dec_t;
endpackage

// File: rtl/nib_cmp_decode.sv
module nib_cmp_decode
  import nib_cmp_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  always_comb begin
    dec = '0;
    if (instr[11:6] == 6'b110111) begin
      dec.legal    = 1'b1;
      dec.imm_form = 1'b1;
      dec.dst_sel  = loc_e'(instr[5:4]);
      dec.imm      = instr[3:0];
    end else if (instr[11:4] == 8'hF0) begin
      dec.legal   = 1'b1;
      dec.dst_sel = loc_e'(instr[3:2]);
      dec.src_sel = loc_e'(instr[1:0]);
    end
  end
endmodule

// File: rtl/nib_cmp_seq.sv
module nib_cmp_seq
  import nib_cmp_pkg::*;
#(
  parameter int CYCLES = 7,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              legal,
  input  logic              imm_form,
  input  loc_e              dst_sel,
  input  loc_e              src_sel,
  input  logic [ADDR_W-1:0] ptr_x,
  input  logic [ADDR_W-1:0] ptr_y,
  output logic              accept,
  output logic              take1,
  output logic              take2,
  output logic              finish,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr
);
  // CYCLES must be at least 5: reads occupy busy cycles 1..3.
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] C_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] C_TWO  = CNT_W'(2);
  localparam logic [CNT_W-1:0] C_THR  = CNT_W'(3);
  localparam logic [CNT_W-1:0] C_PRE  = CNT_W'(CYCLES - 1);
  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(CYCLES);

  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] px, py;
  loc_e              d_sel, s_sel;
  logic              s_mem;
  logic              reject;

  assign busy   = (cnt != '0);
  assign accept = start && !busy && legal;
  assign reject = start && !busy && !legal;
  assign take1  = (cnt == C_TWO) && d_sel[1];
  assign take2  = (cnt == C_THR) && s_mem;
  assign finish = (cnt == C_PRE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      done     <= 1'b0;
      illegal  <= 1'b0;
      mem_rd   <= 1'b0;
      mem_addr <= '0;
      px       <= '0;
      py       <= '0;
      d_sel    <= LOC_A;
      s_sel    <= LOC_A;
      s_mem    <= 1'b0;
    end else begin
      illegal <= reject;
      done    <= finish;
      if (accept)               cnt <= C_ONE;
      else if (cnt == C_LAST)   cnt <= '0;
      else if (busy)            cnt <= cnt + C_ONE;

      if (accept) begin
        px       <= ptr_x;
        py       <= ptr_y;
        d_sel    <= dst_sel;
        s_sel    <= src_sel;
        s_mem    <= !imm_form && src_sel[1];
        mem_rd   <= dst_sel[1];
        mem_addr <= dst_sel[0] ? ptr_y : ptr_x;
      end else if (cnt == C_ONE) begin
        mem_rd <= s_mem;
        if (s_mem) mem_addr <= s_sel[0] ? py : px;
      end else if (cnt == C_TWO) begin
        mem_rd <= 1'b0;
      end
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));
  assert_done_in_busy_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
  assert_read_in_busy_R6: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> busy);
  assert_illegal_idle_R8: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !busy);
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);
endmodule

// File: rtl/nib_cmp_dp.sv
module nib_cmp_dp
  import nib_cmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             imm_form,
  input  loc_e             dst_sel,
  input  loc_e             src_sel,
  input  logic [NIB_W-1:0] imm,
  input  logic [NIB_W-1:0] reg_a,
  input  logic [NIB_W-1:0] reg_b,
  input  logic             take1,
  input  logic             take2,
  input  logic [NIB_W-1:0] mem_rdata,
  input  logic             finish,
  output logic             flag_c,
  output logic             flag_z
);
  logic [NIB_W-1:0] opnd1, opnd2;
  logic [NIB_W:0]   diff;

  function automatic logic [NIB_W-1:0] pick(input loc_e sel, input logic [NIB_W-1:0] a,
                                            input logic [NIB_W-1:0] b);
    case (sel)
      LOC_A:   pick = a;
      LOC_B:   pick = b;
      default: pick = '0;
    endcase
  endfunction

  assign diff = {1'b0, opnd1} - {1'b0, opnd2};

  always_ff @(posedge clk) begin
    if (rst) begin
      opnd1  <= '0;
      opnd2  <= '0;
      flag_c <= 1'b0;
      flag_z <= 1'b0;
    end else begin
      if (accept) begin
        opnd1 <= pick(dst_sel, reg_a, reg_b);
        opnd2 <= imm_form ? imm : pick(src_sel, reg_a, reg_b);
      end
      if (take1) opnd1 <= mem_rdata;
      if (take2) opnd2 <= mem_rdata;
      if (finish) begin
        flag_c <= diff[NIB_W];
        flag_z <= (diff[NIB_W-1:0] == '0);
      end
    end
  end

  assert_c_on_less_R4: assert property (@(posedge clk) disable iff (rst)
    finish |=> (flag_c == (opnd1 < opnd2)));
  assert_z_on_equal_R5: assert property (@(posedge clk) disable iff (rst)
    finish |=> (flag_z == (opnd1 == opnd2)));
endmodule

// File: rtl/nib_cmp_exec.sv
module nib_cmp_exec
  import nib_cmp_pkg::*;
#(
  parameter int CYCLES = 7,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [11:0]       instr,
  input  logic [3:0]        reg_a,
  input  logic [3:0]        reg_b,
  input  logic [ADDR_W-1:0] ptr_x,
  input  logic [ADDR_W-1:0] ptr_y,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [3:0]        mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  output logic              flag_c,
  output logic              flag_z
);
  dec_t dec;
  logic accept, take1, take2, finish;

  nib_cmp_decode u_dec (.instr(instr), .dec(dec));

  nib_cmp_seq #(.CYCLES(CYCLES), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .legal(dec.legal), .imm_form(dec.imm_form),
    .dst_sel(dec.dst_sel), .src_sel(dec.src_sel), .ptr_x(ptr_x), .ptr_y(ptr_y),
    .accept(accept), .take1(take1), .take2(take2), .finish(finish), .busy(busy),
    .done(done), .illegal(illegal), .mem_rd(mem_rd), .mem_addr(mem_addr)
  );

  nib_cmp_dp u_dp (
    .clk(clk), .rst(rst), .accept(accept), .imm_form(dec.imm_form),
    .dst_sel(dec.dst_sel), .src_sel(dec.src_sel), .imm(dec.imm),
    .reg_a(reg_a), .reg_b(reg_b), .take1(take1), .take2(take2),
    .mem_rdata(mem_rdata), .finish(finish), .flag_c(flag_c), .flag_z(flag_z)
  );

  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable({flag_c, flag_z}));
  assert_c_z_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> !(flag_c && flag_z));
endmodule

// File: tb/nib_cmp_exec_tb.sv
module nib_cmp_exec_tb;
  localparam int AW = 8;
  localparam int NC = 7;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1, start = 1'b0;
  logic [11:0]   instr = '0;
  logic [3:0]    reg_a = '0, reg_b = '0;
  logic [AW-1:0] ptr_x = '0, ptr_y = '0;
  logic          mem_rd;
  logic [AW-1:0] mem_addr;
  logic [3:0]    mem_rdata = '0;
  logic          busy, done, illegal, flag_c, flag_z;
  logic [3:0]    mem [0:(1<<AW)-1];

  nib_cmp_exec #(.CYCLES(NC), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .reg_a(reg_a), .reg_b(reg_b),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .illegal(illegal),
    .flag_c(flag_c), .flag_z(flag_z)
  );

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  int checks = 0, errors = 0;
  bit finished = 0;
  typedef struct packed { logic ill; logic c; logic z; } exp_t;
  exp_t sb[$];
  logic ec = 1'b0, ez = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: pop one expected item per done or illegal pulse
  always @(negedge clk) begin
    exp_t e;
    if (!rst && (done || illegal)) begin
      if (sb.size() == 0) chk(0, "R9", "unexpected result pulse", {done, illegal}, 0);
      else begin
        e = sb.pop_front();
        chk(illegal == e.ill, "R8", "illegal pulse", illegal, e.ill);
        chk(flag_c == e.c, "R4", "flag_c", flag_c, e.c);
        chk(flag_z == e.z, "R5", "flag_z", flag_z, e.z);
      end
    end
  end

  function automatic logic [3:0] val(input logic [1:0] s);
    case (s)
      2'b00:   return reg_a;
      2'b01:   return reg_b;
      2'b10:   return mem[ptr_x];
      default: return mem[ptr_y];
    endcase
  endfunction

  task automatic issue(input logic [11:0] op, input bit poke);
    bit immf, legal;
    logic [1:0] d, s;
    logic [3:0] v1, v2;
    int busy_n, done_at;
    immf  = (op[11:6] == 6'b110111);                 // R1
    legal = immf || (op[11:4] == 8'hF0);             // R2
    d = immf ? op[5:4] : op[3:2];
    s = op[1:0];
    @(negedge clk);
    instr = op;
    start = 1'b1;
    if (legal) begin
      v1 = val(d);                                    // R3
      v2 = immf ? op[3:0] : val(s);
      ec = (v1 < v2);
      ez = (v1 == v2);
      sb.push_back({1'b0, ec, ez});
    end else sb.push_back({1'b1, ec, ez});
    @(negedge clk);
    start = 1'b0;
    if (!legal) begin
      chk(busy == 0, "R8", "busy on illegal", busy, 0);
      chk(illegal == 1, "R8", "illegal raised", illegal, 1);
      @(negedge clk);
      chk(illegal == 0, "R8", "illegal one cycle", illegal, 0);
      return;
    end
    chk(mem_rd == d[1], "R6", "first read request", mem_rd, d[1]);
    if (d[1]) chk(mem_addr == (d[0] ? ptr_y : ptr_x), "R6", "first read addr", mem_addr,
                  d[0] ? ptr_y : ptr_x);
    busy_n = 0;
    done_at = 0;
    for (int k = 1; k <= NC + 1; k++) begin
      if (k > 1) @(negedge clk);
      if (k == 2) begin
        chk(mem_rd == (!immf && s[1]), "R6", "second read request", mem_rd, !immf && s[1]);
        if (!immf && s[1]) chk(mem_addr == (s[0] ? ptr_y : ptr_x), "R6", "second read addr",
                               mem_addr, s[0] ? ptr_y : ptr_x);
        if (poke) begin
          instr = 12'h000;
          start = 1'b1;
        end
      end
      if (k == 3) start = 1'b0;
      if (busy) busy_n++;
      if (done) done_at = k;
    end
    chk(busy_n == NC, "R7", "busy length", busy_n, NC);
    chk(done_at == NC, "R7", "done position", done_at, NC);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 4'((i * 7 + 3) & 15);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({flag_c, flag_z, busy, done, illegal, mem_rd} == 6'b0, "R10", "reset state",
        {flag_c, flag_z, busy, done, illegal, mem_rd}, 0);

    reg_a = 4'd4; reg_b = 4'd10;
    ptr_x = 8'h10; ptr_y = 8'h20; mem[8'h10] = 4'd2; mem[8'h20] = 4'd7;
    issue(12'hDC4, 0);  // R1 A==4
    issue(12'hDD2, 0);  // R1 B>2
    issue(12'hDE7, 0);  // R3 MX<7
    issue(12'hDF7, 0);  // R3 MY==7
    issue(12'hF01, 0);  // R2 A<B
    issue(12'hF04, 0);  // R2 B>A
    issue(12'hF0E, 0);  // R6 MY vs MX
    issue(12'hF0A, 0);  // R6 MX vs MX
    issue(12'hF05, 0);  // R5 B vs B
    reg_a = 4'd0;  issue(12'hDCF, 0);  // R4 0 < 15
    reg_a = 4'd15; issue(12'hDC0, 0);  // R4 15 > 0
    issue(12'hDBF, 0);  // R8 just below range
    issue(12'hF10, 0);  // R8 just above range
    issue(12'hE00, 0);  // R8
    reg_a = 4'd3; reg_b = 4'd3;
    issue(12'hF01, 1);  // R9 start during busy
    issue(12'h000, 0);  // R8 flags held after R9 test
    for (int n = 0; n < 60; n++) begin
      logic [5:0] r;
      reg_a = 4'($urandom); reg_b = 4'($urandom);
      ptr_x = AW'($urandom); ptr_y = (n % 5 == 0) ? ptr_x : AW'($urandom);
      r = 6'($urandom);
      issue((n % 2 == 0) ? (12'hDC0 | {6'b0, r}) : (12'hF00 | {8'b0, r[3:0]}), n % 7 == 3);
    end
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R7", "results outstanding", sb.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog expired: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule